// File: doc/BRIEF.md
# Dual-Rail Full Adder with Selectable Completion Style

This block is a one-bit full adder for dual-rail, return-to-spacer datapaths. Each logical signal is carried on a true rail and a false rail. A 1 is (true=1, false=0), a 0 is (true=0, false=1), and the spacer (empty) state is (0,0). The pair (1,1) is never legal. The adder takes the operands a and b and a carry-in c, and it produces a dual-rail sum and a dual-rail carry-out.

Every product term is a state-holding rendezvous gate (a C-element). The gate drives its output high once all of its inputs are high and low once all of its inputs are low. In every other case it keeps its last value. Each C-element is a register clocked by `clk` and cleared by a synchronous active-high `rst`, so every output responds one clock edge after its inputs.

The compile-time parameter `MODE` picks the completion style of the carry logic:
- **Strong:** the carry waits for every input.
- **Weak:** the carry can fire from a and b alone when they generate or kill.
- **Biased:** the carry fires as soon as any two inputs agree.

The sum logic is the same in all three modes. It is always the output that proves all three inputs have arrived and have left.

Top module: `dr_full_adder`

## Requirements
- R1: For one clock edge with `rst` high, all four output rails read 0, which is spacer on both outputs.
- R2: When all three inputs hold valid codes, the edge after they became valid leaves sum = a XOR b XOR c and carry = majority(a,b,c) on the output rails, with 1 encoded as (true,false)=(1,0) and 0 as (0,1).
- R3: Neither output pair ever reads (1,1).
- R4: In every mode the sum leaves spacer only after an edge at which all three inputs were valid. It returns to spacer only after an edge at which all three inputs were spacer, and in between it holds its value.
- R5: In strong mode the carry sets only after an edge with all three inputs valid and clears only after an edge with all three inputs spacer.
- R6: In weak mode, valid and equal a and b set the carry to their common value one edge later, even while c is spacer.
- R7: In weak mode, with a and b valid and unequal and c spacer, the carry stays spacer.
- R8: In biased mode, any two valid inputs with the same value set the carry to that value one edge later, even while the third input is spacer.
- R9: In weak and biased modes, after a=1, b=1, c=0, taking a and b to spacer while c stays valid returns the carry to spacer while the sum holds 0. In strong mode the carry holds 1 under the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state-holding gates |
| rst | input | 1 | Synchronous active-high reset to spacer |
| a_t | input | 1 | Operand a, true rail |
| a_f | input | 1 | Operand a, false rail |
| b_t | input | 1 | Operand b, true rail |
| b_f | input | 1 | Operand b, false rail |
| c_t | input | 1 | Carry-in, true rail |
| c_f | input | 1 | Carry-in, false rail |
| sum_t | output | 1 | Sum, true rail |
| sum_f | output | 1 | Sum, false rail |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |

## Verification
The bench instantiates the adder in all three modes and drives the same stimulus to each copy.

The first pattern applies all three inputs at once, for each of the eight combinations. This confirms that the modes agree on the arithmetic.

The second pattern lets the inputs arrive one per clock in random order. After each arrival the bench checks whether a carry has already appeared. This is the pattern that separates the three carry rules: strong waits for all inputs, weak needs an agreeing a and b, and biased needs any agreeing pair.

The third pattern is a directed partial return to spacer. It shows that the sum always holds until the last input clears, while an eager carry clears early.

// File: rtl/dr_fa_pkg.sv
package dr_fa_pkg;

  typedef enum logic [1:0] {
    IND_STRONG = 2'd0,
    IND_WEAK   = 2'd1,
    IND_BIASED = 2'd2
  } ind_mode_e;

  localparam int unsigned NUM_IN = 3;
  localparam int unsigned NUM_MT = 1 << NUM_IN;

  // Mask of minterms (index = {a,b,c}) whose parity is odd.
  function automatic logic [NUM_MT-1:0] odd_mask();
    logic [NUM_MT-1:0] m;
    for (int k = 0; k < NUM_MT; k++) begin
      m[k] = ^(k[NUM_IN-1:0]);
    end
    return m;
  endfunction

  // Mask of minterms with at least two ones.
  function automatic logic [NUM_MT-1:0] maj_mask();
    logic [NUM_MT-1:0] m;
    for (int k = 0; k < NUM_MT; k++) begin
      m[k] = ($countones(k[NUM_IN-1:0]) >= 2);
    end
    return m;
  endfunction

endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in,
  output logic         q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (&in) begin
      q <= 1'b1;
    end else if (~|in) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/dr_minterm_bank.sv
module dr_minterm_bank
  import dr_fa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              a_t,
  input  logic              a_f,
  input  logic              b_t,
  input  logic              b_f,
  input  logic              c_t,
  input  logic              c_f,
  output logic [NUM_MT-1:0] mt
);

  for (genvar i = 0; i < NUM_MT; i++) begin : g_mt
    localparam logic [NUM_IN-1:0] SEL = i[NUM_IN-1:0];
    logic [NUM_IN-1:0] ins;
    assign ins[2] = SEL[2] ? a_t : a_f;
    assign ins[1] = SEL[1] ? b_t : b_f;
    assign ins[0] = SEL[0] ? c_t : c_f;
    dr_celem #(.N(NUM_IN)) u_c (
      .clk (clk),
      .rst (rst),
      .in  (ins),
      .q   (mt[i])
    );
  end

endmodule

// File: rtl/dr_carry_eager.sv
module dr_carry_eager
  import dr_fa_pkg::*;
#(
  parameter ind_mode_e MODE = IND_WEAK
) (
  input  logic clk,
  input  logic rst,
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  input  logic c_t,
  input  logic c_f,
  output logic cout_t,
  output logic cout_f
);

  localparam int unsigned NT = 3;

  logic [NT-1:0] t_q;
  logic [NT-1:0] f_q;

  // Term 0 is shared by both styles: a and b agree.
  dr_celem #(.N(2)) u_t0 (.clk(clk), .rst(rst), .in({a_t, b_t}), .q(t_q[0]));
  dr_celem #(.N(2)) u_f0 (.clk(clk), .rst(rst), .in({a_f, b_f}), .q(f_q[0]));

  if (MODE == IND_BIASED) begin : g_biased
    dr_celem #(.N(2)) u_t1 (.clk(clk), .rst(rst), .in({a_t, c_t}), .q(t_q[1]));
    dr_celem #(.N(2)) u_t2 (.clk(clk), .rst(rst), .in({b_t, c_t}), .q(t_q[2]));
    dr_celem #(.N(2)) u_f1 (.clk(clk), .rst(rst), .in({a_f, c_f}), .q(f_q[1]));
    dr_celem #(.N(2)) u_f2 (.clk(clk), .rst(rst), .in({b_f, c_f}), .q(f_q[2]));
  end else begin : g_weak
    // Propagate cases must see the carry-in.
    dr_celem #(.N(3)) u_t1 (.clk(clk), .rst(rst), .in({a_t, b_f, c_t}), .q(t_q[1]));
    dr_celem #(.N(3)) u_t2 (.clk(clk), .rst(rst), .in({a_f, b_t, c_t}), .q(t_q[2]));
    dr_celem #(.N(3)) u_f1 (.clk(clk), .rst(rst), .in({a_t, b_f, c_f}), .q(f_q[1]));
    dr_celem #(.N(3)) u_f2 (.clk(clk), .rst(rst), .in({a_f, b_t, c_f}), .q(f_q[2]));
  end

  assign cout_t = |t_q;
  assign cout_f = |f_q;

endmodule

// File: rtl/dr_full_adder.sv
module dr_full_adder
  import dr_fa_pkg::*;
#(
  parameter ind_mode_e MODE = IND_STRONG
) (
  input  logic clk,
  input  logic rst,
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  input  logic c_t,
  input  logic c_f,
  output logic sum_t,
  output logic sum_f,
  output logic cout_t,
  output logic cout_f
);

  localparam logic [NUM_MT-1:0] ODD = odd_mask();
  localparam logic [NUM_MT-1:0] MAJ = maj_mask();

  logic [NUM_MT-1:0] mt;

  dr_minterm_bank u_bank (
    .clk (clk),
    .rst (rst),
    .a_t (a_t),
    .a_f (a_f),
    .b_t (b_t),
    .b_f (b_f),
    .c_t (c_t),
    .c_f (c_f),
    .mt  (mt)
  );

  assign sum_t = |(mt & ODD);
  assign sum_f = |(mt & ~ODD);

  if (MODE == IND_STRONG) begin : g_strong
    assign cout_t = |(mt & MAJ);
    assign cout_f = |(mt & ~MAJ);
  end else begin : g_eager
    dr_carry_eager #(.MODE(MODE)) u_carry (
      .clk    (clk),
      .rst    (rst),
      .a_t    (a_t),
      .a_f    (a_f),
      .b_t    (b_t),
      .b_f    (b_f),
      .c_t    (c_t),
      .c_f    (c_f),
      .cout_t (cout_t),
      .cout_f (cout_f)
    );
  end

endmodule

// File: rtl/dr_full_adder_chk.sv
module dr_full_adder_chk
  import dr_fa_pkg::*;
#(
  parameter ind_mode_e MODE = IND_STRONG
) (
  input logic clk,
  input logic rst,
  input logic a_t,
  input logic a_f,
  input logic b_t,
  input logic b_f,
  input logic c_t,
  input logic c_f,
  input logic sum_t,
  input logic sum_f,
  input logic cout_t,
  input logic cout_f
);

  logic av, bv, cv, all_v, all_s;
  assign av    = a_t | a_f;
  assign bv    = b_t | b_f;
  assign cv    = c_t | c_f;
  assign all_v = av & bv & cv;
  assign all_s = ~(av | bv | cv);

  a_r3_sum_rails: assert property (@(posedge clk) disable iff (rst)
    !(sum_t && sum_f));
  a_r3_cout_rails: assert property (@(posedge clk) disable iff (rst)
    !(cout_t && cout_f));

  a_r4_sum_set: assert property (@(posedge clk) disable iff (rst)
    $rose(sum_t | sum_f) |-> $past(all_v));
  a_r4_sum_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(sum_t | sum_f) |-> $past(all_s));

  a_r2_sum_odd: assert property (@(posedge clk) disable iff (rst)
    $rose(sum_t) |-> $past(a_t ^ b_t ^ c_t));

  if (MODE == IND_STRONG) begin : g_strong
    a_r5_cout_set: assert property (@(posedge clk) disable iff (rst)
      $rose(cout_t | cout_f) |-> $past(all_v));
    a_r5_cout_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(cout_t | cout_f) |-> $past(all_s));
  end else if (MODE == IND_WEAK) begin : g_weak
    a_r7_cout_needs_ab: assert property (@(posedge clk) disable iff (rst)
      $rose(cout_t | cout_f) |-> $past(av && bv));
  end else begin : g_biased
    a_r8_cout_pair: assert property (@(posedge clk) disable iff (rst)
      $rose(cout_t) |-> $past((a_t && b_t) || (a_t && c_t) || (b_t && c_t)));
  end

endmodule

bind dr_full_adder dr_full_adder_chk #(.MODE(MODE)) u_chk (.*);

// File: tb/test_dr_full_adder.sv
module test_dr_full_adder;
  import dr_fa_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NMODE      = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_t = 0, a_f = 0, b_t = 0, b_f = 0, c_t = 0, c_f = 0;
  logic [NMODE-1:0] s_t, s_f, k_t, k_f;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dr_full_adder #(.MODE(IND_STRONG)) i_dr_full_adder (
    .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .c_t(c_t), .c_f(c_f), .sum_t(s_t[0]), .sum_f(s_f[0]),
    .cout_t(k_t[0]), .cout_f(k_f[0]));
  dr_full_adder #(.MODE(IND_WEAK)) i_dr_full_adder_weak (
    .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .c_t(c_t), .c_f(c_f), .sum_t(s_t[1]), .sum_f(s_f[1]),
    .cout_t(k_t[1]), .cout_f(k_f[1]));
  dr_full_adder #(.MODE(IND_BIASED)) i_dr_full_adder_biased (
    .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .c_t(c_t), .c_f(c_f), .sum_t(s_t[2]), .sum_f(s_f[2]),
    .cout_t(k_t[2]), .cout_f(k_f[2]));

  function automatic logic [1:0] enc(input logic v);
    return v ? 2'b10 : 2'b01;
  endfunction

  function automatic logic carry_ready(input int m, input logic va, vb, vc,
                                       input logic a, b, c);
    logic all3;
    all3 = va & vb & vc;
    case (m)
      0:       return all3;
      1:       return all3 | (va & vb & (a == b));
      default: return all3 | (va & vb & (a == b)) | (va & vc & (a == c))
                           | (vb & vc & (b == c));
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int m,
                     input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s mode%0d: actual %b expected %b", req, what, m, act, exp);
    end
  endtask

  task automatic drive(input logic va, a, vb, b, vc, c);
    @(negedge clk);
    a_t = va & a;  a_f = va & ~a;
    b_t = vb & b;  b_f = vb & ~b;
    c_t = vc & c;  c_f = vc & ~c;
    @(negedge clk);
  endtask

  task automatic no_both(input string req);
    for (int m = 0; m < NMODE; m++) begin
      checks++;
      if ((s_t[m] & s_f[m]) | (k_t[m] & k_f[m])) begin
        errors++;
        $display("FAIL %s mode%0d: actual sum=%b%b cout=%b%b expected no 11",
                 req, m, s_t[m], s_f[m], k_t[m], k_f[m]);
      end
    end
  endtask

  // Check all instances for a monotone arrival state.
  task automatic check_state(input string req, input logic va, vb, vc,
                             input logic a, b, c);
    logic all3;
    logic [1:0] es, ec;
    all3 = va & vb & vc;
    es = all3 ? enc(a ^ b ^ c) : 2'b00;
    for (int m = 0; m < NMODE; m++) begin
      ec = carry_ready(m, va, vb, vc, a, b, c)
           ? enc((a & b) | (a & c) | (b & c)) : 2'b00;
      chk(req, "sum", m, {s_t[m], s_f[m]}, es);
      chk(req, "cout", m, {k_t[m], k_f[m]}, ec);
    end
    no_both("R3");
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0f0a;
    void'($urandom(seed));

    // R1: reset state.
    repeat (3) @(negedge clk);
    for (int m = 0; m < NMODE; m++)
      chk("R1", "rails", m, {s_t[m], s_f[m], k_t[m], k_f[m]}, 4'b0000);
    rst = 1'b0;

    // R2: all eight combinations applied at once.
    for (int v = 0; v < 8; v++) begin
      drive(1, v[2], 1, v[1], 1, v[0]);
      check_state("R2", 1, 1, 1, v[2], v[1], v[0]);
      drive(0, 0, 0, 0, 0, 0);
      check_state("R4", 0, 0, 0, 0, 0, 0);
    end

    // R6: weak generate/kill with carry-in spacer; R7: propagate waits.
    drive(1, 1, 1, 1, 0, 0);
    chk("R6", "cout", 1, {k_t[1], k_f[1]}, 2'b10);
    chk("R4", "sum", 1, {s_t[1], s_f[1]}, 2'b00);
    chk("R5", "cout", 0, {k_t[0], k_f[0]}, 2'b00);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0);
    chk("R6", "cout kill", 1, {k_t[1], k_f[1]}, 2'b01);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 1, 1, 0, 0, 0);
    chk("R7", "cout", 1, {k_t[1], k_f[1]}, 2'b00);
    drive(0, 0, 0, 0, 0, 0);

    // R8: biased fires on a and c agreeing with b spacer; weak does not.
    drive(1, 1, 0, 0, 1, 1);
    chk("R8", "cout", 2, {k_t[2], k_f[2]}, 2'b10);
    chk("R7", "cout a,c only", 1, {k_t[1], k_f[1]}, 2'b00);
    drive(0, 0, 0, 0, 0, 0);

    // R9: partial return to spacer with c still valid.
    drive(1, 1, 1, 1, 1, 0);
    drive(0, 0, 0, 0, 1, 0);
    for (int m = 0; m < NMODE; m++)
      chk("R9", "sum hold", m, {s_t[m], s_f[m]}, 2'b01);
    chk("R9", "cout strong hold", 0, {k_t[0], k_f[0]}, 2'b10);
    chk("R9", "cout weak clear", 1, {k_t[1], k_f[1]}, 2'b00);
    chk("R9", "cout biased clear", 2, {k_t[2], k_f[2]}, 2'b00);
    drive(0, 0, 0, 0, 0, 0);
    check_state("R4", 0, 0, 0, 0, 0, 0);

    // Random arrival order, one input per cycle, then a full spacer.
    for (int t = 0; t < 60; t++) begin
      logic a, b, c, va, vb, vc;
      int o0, o1;
      a = $urandom() & 1; b = $urandom() & 1; c = $urandom() & 1;
      va = 0; vb = 0; vc = 0;
      o0 = $urandom_range(0, 2);
      o1 = (o0 + 1 + $urandom_range(0, 1)) % 3;
      for (int s = 0; s < 3; s++) begin
        int pick;
        pick = (s == 0) ? o0 : (s == 1) ? o1 : 3 - o0 - o1;
        if (pick == 0) va = 1; else if (pick == 1) vb = 1; else vc = 1;
        drive(va, a, vb, b, vc, c);
        check_state((s == 2) ? "R2" : "R5/R6/R8", va, vb, vc, a, b, c);
      end
      drive(0, 0, 0, 0, 0, 0);
      check_state("R4", 0, 0, 0, 0, 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule